// File: doc/BRIEF.md
# Serial EEPROM Word Reader with Size Autodetect

This block fetches 16-bit words from a small serial EEPROM over a four-wire link. The four wires are a chip select, a serial clock, a data line toward the memory and a data line back from it. A client pulses a start strobe with a word address. The block then raises chip select and shifts out a start bit, the read opcode and the address. It shifts in the sixteen data bits and returns the word with a one-cycle done pulse. Chip select then stays low for a full serial period before any later transaction.

The block must work with memories of 64, 128, 256, 512 or 1024 words, which need 6 to 10 address bits. Leaving reset, it sends one read frame of its own and feeds in address zeros one at a time. It watches for the leading zero that a memory drives once it has taken its last address bit. The number of bits sent by then is the address width. If that zero never comes within ten bits, or comes too early to be real, no usable memory is attached. The result lets a boot sequence skip the whole load at once.

A software path can also take the pins directly. While it is enabled, three control bits drive chip select, clock and data-out. The returning data line can be read back on a status output. Meanwhile the engine refuses new requests.

Top module: `mw_reader`

## Requirements
- R1: While reset is held, `eep_cs`, `eep_sk`, `rd_done` and `det_done` are low and `rd_busy` is high. After release, `rd_busy` stays high until the size probe has ended and `det_done` has risen.
- R2: A read frame keeps `eep_cs` high for the whole frame, and `eep_sk` is low whenever `eep_cs` is low. The frame sends the bits 1, 1, 0 (start bit, then opcode 10), then the address MSB first using exactly the detected number of bits. Each bit is placed while `eep_sk` is low, to be taken on its rising edge.
- R3: The sixteen bits that follow the memory's leading zero are sampled MSB first and appear on `rd_data` when `rd_done` pulses for one cycle. `rd_busy` is high from the cycle after an accepted start until the cycle in which `rd_done` pulses.
- R4: When the memory's leading zero is first seen after n address bits, with 6 <= n <= 10, `dev_present` goes to 1 and `addr_bits` to n. `det_done` then rises and holds until the next reset.
- R5: When the return line is still high after ten address bits, `dev_present` is 0 when `det_done` rises.
- R6: When the return line is low after fewer than six address bits (a line held low), `dev_present` is 0 when `det_done` rises.
- R7: With no memory detected, a start gives `rd_done` in the next cycle with `rd_data` = 16'hFFFF, and `eep_cs` stays low.
- R8: Address bits at or above the detected width are ignored. A read of an address with those bits set returns the same word, and sends the same address, as the masked address.
- R9: Each half of the serial clock lasts `CLK_DIV` system cycles. Between two frames, `eep_cs` stays low for at least 2*`CLK_DIV` cycles.
- R10: With `sw_en` = 1, the pins follow `sw_pins` in the same cycle: bit 0 drives `eep_cs`, bit 1 `eep_sk` and bit 2 `eep_di`. `sw_rd` shows `eep_do` one clock edge later.
- R11: A start is ignored while `rd_busy` is high, while `sw_en` is 1, or before `det_done` has risen. No frame is started, and the data of the read in progress is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_start | input | 1 | Read request strobe |
| rd_addr | input | 10 | Word address of the request |
| rd_busy | output | 1 | Probe or read in progress |
| rd_done | output | 1 | One-cycle pulse, read word valid |
| rd_data | output | 16 | Last word read |
| det_done | output | 1 | Size probe has ended |
| dev_present | output | 1 | A usable memory was found |
| addr_bits | output | 4 | Detected address width |
| sw_en | input | 1 | Software pin control enable |
| sw_pins | input | 3 | Software pin values: cs, sk, di |
| sw_rd | output | 1 | Registered return data line |
| eep_cs | output | 1 | Memory chip select |
| eep_sk | output | 1 | Memory serial clock |
| eep_di | output | 1 | Serial data to the memory |
| eep_do | input | 1 | Serial data from the memory |

## Verification
A wrong bit counter or a wrong stored width shows up first on the address the memory model receives. It then shows as a shifted or rotated word on `rd_data`, within the first read after the probe. A probe that takes the wrong exit shows as a wrong `dev_present` or `addr_bits` as soon as `det_done` rises, some hundred cycles after reset. A broken gap or phase counter shows as a shortened chip-select low time or clock half-period in the very next frame.

// File: rtl/mw_pkg.sv
package mw_pkg;
    localparam int ADDR_MIN = 6;
    localparam int ADDR_MAX = 10;
    localparam int DATA_W   = 16;
    localparam int CMD_W    = 3;
    localparam int IDX_W    = $clog2(CMD_W + ADDR_MAX + DATA_W);
    localparam int WB_W     = $clog2(ADDR_MAX + 1);

    typedef enum logic [1:0] {
        ST_BOOT,
        ST_SHIFT,
        ST_GAP,
        ST_IDLE
    } mw_state_e;
endpackage

// File: rtl/mw_clkdiv.sv
module mw_clkdiv #(
    parameter int CLK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } div_t;

    div_t q, d;

    always_comb begin
        d    = q;
        tick = 1'b0;
        if (!run) begin
            d.cnt = '0;
        end else if (q.cnt == CW'(CLK_DIV - 1)) begin
            d.cnt = '0;
            tick  = 1'b1;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/mw_pinmux.sv
module mw_pinmux (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sw_en,
    input  logic [2:0] sw_pins,
    input  logic       eng_cs,
    input  logic       eng_sk,
    input  logic       eng_di,
    input  logic       eep_do,
    output logic       eep_cs,
    output logic       eep_sk,
    output logic       eep_di,
    output logic       do_s
);
    typedef struct packed {
        logic din;
    } mux_t;

    mux_t q, d;

    always_comb begin
        d.din  = eep_do;
        eep_cs = sw_en ? sw_pins[0] : eng_cs;
        eep_sk = sw_en ? sw_pins[1] : eng_sk;
        eep_di = sw_en ? sw_pins[2] : eng_di;
    end

    assign do_s = q.din;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{din: 1'b1};
        else        q <= d;
    end
endmodule

// File: rtl/mw_engine.sv
module mw_engine
    import mw_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                start,
    input  logic [ADDR_MAX-1:0] addr,
    input  logic                sw_en,
    input  logic                do_s,
    output logic                run,
    output logic                busy,
    output logic                done,
    output logic [DATA_W-1:0]   rdata,
    output logic                det_done,
    output logic                dev_present,
    output logic [WB_W-1:0]     addr_bits,
    output logic                cs,
    output logic                sk,
    output logic                di
);
    typedef struct packed {
        mw_state_e         st;
        logic              rd;
        logic              ph;
        logic [IDX_W-1:0]  idx;
        logic              gap;
        logic [DATA_W-1:0] sh;
        logic [WB_W-1:0]   w;
        logic              pres;
        logic              det;
        logic              done;
        logic [DATA_W-1:0] rdata;
    } eng_t;

    eng_t q, d;

    logic [IDX_W-1:0]    last_idx;
    logic [IDX_W-1:0]    addr_end;
    logic [IDX_W-1:0]    nsent;
    logic [ADDR_MAX-1:0] aligned;

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        addr_end = IDX_W'(CMD_W) + IDX_W'(q.w);
        last_idx = addr_end + IDX_W'(DATA_W - 1);
        nsent    = q.idx - IDX_W'(CMD_W - 1);
        aligned  = addr << (WB_W'(ADDR_MAX) - q.w);

        case (q.st)
            ST_BOOT: begin
                d.st  = ST_SHIFT;
                d.rd  = 1'b0;
                d.ph  = 1'b0;
                d.idx = '0;
            end
            ST_IDLE: begin
                if (start && !sw_en && q.det) begin
                    if (q.pres) begin
                        d.st  = ST_SHIFT;
                        d.rd  = 1'b1;
                        d.ph  = 1'b0;
                        d.idx = '0;
                        d.sh  = {aligned, {(DATA_W-ADDR_MAX){1'b0}}};
                    end else if (!q.done) begin
                        d.done  = 1'b1;
                        d.rdata = '1;
                    end
                end
            end
            ST_SHIFT: begin
                if (tick) begin
                    if (!q.ph) begin
                        d.ph = 1'b1;
                    end else begin
                        d.ph  = 1'b0;
                        d.idx = q.idx + 1'b1;
                        if (q.idx >= IDX_W'(CMD_W)) begin
                            d.sh = {q.sh[DATA_W-2:0], do_s};
                        end
                        if (!q.rd) begin
                            if (q.idx >= IDX_W'(CMD_W)) begin
                                if (!do_s) begin
                                    d.st  = ST_GAP;
                                    d.gap = 1'b0;
                                    if (nsent >= IDX_W'(ADDR_MIN)) begin
                                        d.pres = 1'b1;
                                        d.w    = WB_W'(nsent);
                                    end else begin
                                        d.pres = 1'b0;
                                    end
                                end else if (nsent == IDX_W'(ADDR_MAX)) begin
                                    d.st   = ST_GAP;
                                    d.gap  = 1'b0;
                                    d.pres = 1'b0;
                                end
                            end
                        end else if (q.idx == last_idx) begin
                            d.st  = ST_GAP;
                            d.gap = 1'b0;
                        end
                    end
                end
            end
            ST_GAP: begin
                if (tick) begin
                    if (!q.gap) begin
                        d.gap = 1'b1;
                    end else begin
                        d.st = ST_IDLE;
                        if (q.rd) begin
                            d.done  = 1'b1;
                            d.rdata = q.sh;
                        end else begin
                            d.det = 1'b1;
                        end
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_comb begin
        cs = (q.st == ST_SHIFT);
        sk = (q.st == ST_SHIFT) && q.ph;
        di = 1'b0;
        if (q.st == ST_SHIFT) begin
            if (q.idx < IDX_W'(CMD_W)) begin
                di = (q.idx != IDX_W'(CMD_W - 1));
            end else if (q.rd && (q.idx < addr_end)) begin
                di = q.sh[DATA_W-1];
            end
        end
    end

    assign run         = (q.st == ST_SHIFT) || (q.st == ST_GAP);
    assign busy        = (q.st != ST_IDLE);
    assign done        = q.done;
    assign rdata       = q.rdata;
    assign det_done    = q.det;
    assign dev_present = q.pres;
    assign addr_bits   = q.w;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_BOOT;
            q.rdata <= '1;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/mw_reader.sv
module mw_reader
    import mw_pkg::*;
#(
    parameter int CLK_DIV = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd_start,
    input  logic [ADDR_MAX-1:0] rd_addr,
    output logic                rd_busy,
    output logic                rd_done,
    output logic [DATA_W-1:0]   rd_data,
    output logic                det_done,
    output logic                dev_present,
    output logic [WB_W-1:0]     addr_bits,
    input  logic                sw_en,
    input  logic [2:0]          sw_pins,
    output logic                sw_rd,
    output logic                eep_cs,
    output logic                eep_sk,
    output logic                eep_di,
    input  logic                eep_do
);
    logic run, tick, do_s;
    logic eng_cs, eng_sk, eng_di;

    mw_clkdiv #(.CLK_DIV(CLK_DIV)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick)
    );

    mw_engine u_eng (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .start       (rd_start),
        .addr        (rd_addr),
        .sw_en       (sw_en),
        .do_s        (do_s),
        .run         (run),
        .busy        (rd_busy),
        .done        (rd_done),
        .rdata       (rd_data),
        .det_done    (det_done),
        .dev_present (dev_present),
        .addr_bits   (addr_bits),
        .cs          (eng_cs),
        .sk          (eng_sk),
        .di          (eng_di)
    );

    mw_pinmux u_mux (
        .clk     (clk),
        .rst_n   (rst_n),
        .sw_en   (sw_en),
        .sw_pins (sw_pins),
        .eng_cs  (eng_cs),
        .eng_sk  (eng_sk),
        .eng_di  (eng_di),
        .eep_do  (eep_do),
        .eep_cs  (eep_cs),
        .eep_sk  (eep_sk),
        .eep_di  (eep_di),
        .do_s    (do_s)
    );

    assign sw_rd = do_s;
endmodule

// File: rtl/mw_reader_chk.sv
module mw_reader_chk #(
    parameter int CLK_DIV = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_busy,
    input logic       rd_done,
    input logic       det_done,
    input logic       dev_present,
    input logic [3:0] addr_bits,
    input logic       sw_en,
    input logic       eep_cs,
    input logic       eep_sk
);
    int unsigned low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               low_cnt <= 32'hFFFF_FFFF;
        else if (eep_cs)          low_cnt <= 0;
        else if (low_cnt != 32'hFFFF_FFFF) low_cnt <= low_cnt + 1;
    end

    // R9
    cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_en && $rose(eep_cs)) |-> (low_cnt >= 2 * CLK_DIV));

    // R2
    sk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_en && !eep_cs) |-> !eep_sk);

    // R4
    width_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (det_done && dev_present) |-> (addr_bits >= 4'd6 && addr_bits <= 4'd10));

    // R4
    det_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        det_done |=> (det_done && $stable(dev_present) && $stable(addr_bits)));

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |=> !rd_done);

    // R3
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |-> !rd_busy);

    // R7
    absent_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (det_done && !dev_present && !sw_en) |-> !eep_cs);

    // R11
    sw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_en && !rd_busy) |=> !rd_busy);
endmodule

bind mw_reader mw_reader_chk #(.CLK_DIV(CLK_DIV)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_busy     (rd_busy),
    .rd_done     (rd_done),
    .det_done    (det_done),
    .dev_present (dev_present),
    .addr_bits   (addr_bits),
    .sw_en       (sw_en),
    .eep_cs      (eep_cs),
    .eep_sk      (eep_sk)
);

// File: tb/mw_reader_bench.sv
`timescale 1ns/1ps
module mw_reader_bench;
    localparam int CLK_DIV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_start = 1'b0;
    logic [9:0]  rd_addr = '0;
    logic        rd_busy, rd_done, det_done, dev_present, sw_rd;
    logic [15:0] rd_data;
    logic [3:0]  addr_bits;
    logic        sw_en = 1'b0;
    logic [2:0]  sw_pins = '0;
    logic        eep_cs, eep_sk, eep_di, eep_do;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    mw_reader #(.CLK_DIV(CLK_DIV)) u_mw_reader (
        .clk(clk), .rst_n(rst_n), .rd_start(rd_start), .rd_addr(rd_addr),
        .rd_busy(rd_busy), .rd_done(rd_done), .rd_data(rd_data),
        .det_done(det_done), .dev_present(dev_present), .addr_bits(addr_bits),
        .sw_en(sw_en), .sw_pins(sw_pins), .sw_rd(sw_rd),
        .eep_cs(eep_cs), .eep_sk(eep_sk), .eep_di(eep_di), .eep_do(eep_do)
    );

    // memory model
    int          m_w = 8;
    logic        m_present = 1'b1;
    logic        m_stuck = 1'b0;
    logic        m_do, m_started;
    int          m_cnt;
    logic [9:0]  m_addr, m_last_addr;
    logic [1:0]  m_op;
    logic [15:0] m_word;

    function automatic logic [15:0] mem_word(input logic [9:0] a);
        logic [31:0] t;
        t = {22'd0, a} * 32'h9E37_79B1 + 32'h0000_1357;
        return t[31:16] ^ t[15:0];
    endfunction

    assign m_word = mem_word(m_addr);
    assign eep_do = m_stuck ? 1'b0 : ((m_present && eep_cs) ? m_do : 1'b1);

    always @(posedge eep_sk or negedge eep_cs) begin
        if (!eep_cs) begin
            m_started <= 1'b0;
            m_cnt     <= 0;
            m_do      <= 1'b1;
            m_addr    <= '0;
        end else if (!m_started) begin
            if (eep_di) m_started <= 1'b1;
            m_cnt <= 0;
        end else begin
            if (m_cnt < 2) m_op <= {m_op[0], eep_di};
            else if (m_cnt < 2 + m_w) m_addr <= {m_addr[8:0], eep_di};
            if (m_cnt == 2 + m_w) m_last_addr <= m_addr;
            if (m_cnt == 1 + m_w) m_do <= 1'b0;
            else if (m_cnt >= 2 + m_w && m_cnt < 18 + m_w) m_do <= m_word[17 + m_w - m_cnt];
            else m_do <= 1'b1;
            m_cnt <= m_cnt + 1;
        end
    end

    // timing monitors for R9
    int cs_low = 1000000, min_gap = 1000000;
    int sk_hi = 0, min_hi = 1000000, max_hi = 0;
    always @(posedge clk) begin
        if (!eep_cs) cs_low <= cs_low + 1;
        else begin
            if (!sw_en && cs_low > 0 && cs_low < min_gap) min_gap <= cs_low;
            cs_low <= 0;
        end
        if (!sw_en && rst_n) begin
            if (eep_sk) sk_hi <= sk_hi + 1;
            else if (sk_hi > 0) begin
                if (sk_hi < min_hi) min_hi <= sk_hi;
                if (sk_hi > max_hi) max_hi <= sk_hi;
                sk_hi <= 0;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    task automatic do_reset(input int w, input bit pres, input bit stuck);
        @(negedge clk);
        rst_n = 1'b0;
        m_w = w; m_present = pres; m_stuck = stuck;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!eep_cs && !eep_sk && !rd_done && !det_done && rd_busy, "R1 reset",
            {eep_cs, eep_sk, rd_done, det_done, rd_busy}, 5'b00001);
        rst_n = 1'b1;
        begin
            int n = 0;
            bit early = 0;
            while (!det_done && n < 3000) begin
                @(negedge clk);
                if (!det_done && !rd_busy) early = 1;
                n++;
            end
            chk(det_done && !early, "R1 probe ends with busy held", {det_done, early}, 2'b10);
        end
    endtask

    task automatic do_read(input logic [9:0] a, output logic [15:0] d, output int cyc);
        @(negedge clk);
        rd_start = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_start = 1'b0;
        cyc = 0;
        while (!rd_done && cyc < 3000) begin
            @(negedge clk);
            cyc++;
        end
        if (!rd_done) chk(0, "R3 read timeout", cyc, 0);
        d = rd_data;
    endtask

    task automatic read_check(input logic [9:0] a, input int w);
        logic [15:0] d;
        logic [9:0] mask, exp_a;
        int cyc;
        mask = 10'((1 << w) - 1);
        exp_a = a & mask;
        do_read(a, d, cyc);
        chk(d == mem_word(exp_a), "R3 read data", d, mem_word(exp_a));
        chk(m_op == 2'b10 && m_last_addr == exp_a, "R2 command and address",
            {m_op, m_last_addr}, {2'b10, exp_a});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        summary();
        $finish;
    end

    initial begin
        logic [15:0] d, d2;
        int cyc;
        void'($urandom(32'd20240611));

        for (int w = 6; w <= 10; w++) begin
            do_reset(w, 1'b1, 1'b0);
            // R4 detected width
            chk(dev_present && addr_bits == 4'(w), "R4 width detect",
                {dev_present, addr_bits}, {1'b1, 4'(w)});
            read_check(10'd0, w);
            read_check(10'h3FF, w);
            for (int k = 0; k < 6; k++) read_check(10'($urandom), w);
            // R8 upper bits ignored
            begin
                logic [9:0] base;
                base = 10'($urandom) & 10'((1 << w) - 1);
                do_read(base, d, cyc);
                do_read(base | ~10'((1 << w) - 1), d2, cyc);
                chk(d == d2 && m_last_addr == base, "R8 upper address bits ignored",
                    {d2, m_last_addr}, {d, base});
            end
        end

        // R11 start while busy
        begin
            logic [9:0] a = 10'h05A & 10'h3FF;
            int extra = 0;
            @(negedge clk);
            rd_start = 1'b1; rd_addr = a;
            @(negedge clk);
            rd_start = 1'b0;
            repeat (30) @(negedge clk);
            rd_start = 1'b1; rd_addr = 10'h2C3;
            @(negedge clk);
            rd_start = 1'b0;
            while (!rd_done) @(negedge clk);
            d = rd_data;
            chk(d == mem_word(a) && m_last_addr == a, "R11 start during busy ignored",
                d, mem_word(a));
            repeat (40) begin
                @(negedge clk);
                if (rd_busy || rd_done) extra++;
            end
            chk(extra == 0, "R11 no second frame", extra, 0);
        end

        // R10 software pin control, R11 start ignored under software control
        @(negedge clk);
        sw_en = 1'b1;
        for (int p = 0; p < 8; p++) begin
            sw_pins = 3'(p);
            #1;
            chk({eep_di, eep_sk, eep_cs} == 3'(p), "R10 pins follow software",
                {eep_di, eep_sk, eep_cs}, p);
            @(negedge clk);
        end
        sw_pins = 3'b000;
        @(negedge clk);
        @(negedge clk);
        chk(sw_rd == 1'b1, "R10 sw_rd high line", sw_rd, 1);
        m_stuck = 1'b1;
        @(negedge clk);
        chk(sw_rd == 1'b0, "R10 sw_rd low line", sw_rd, 0);
        m_stuck = 1'b0;
        @(negedge clk);
        chk(sw_rd == 1'b1, "R10 sw_rd back high", sw_rd, 1);
        rd_start = 1'b1; rd_addr = 10'h011;
        @(negedge clk);
        rd_start = 1'b0;
        begin
            int act = 0;
            repeat (20) begin
                @(negedge clk);
                if (rd_busy || rd_done) act++;
            end
            chk(act == 0, "R11 start ignored under software control", act, 0);
        end
        sw_en = 1'b0;
        repeat (4) @(negedge clk);

        // R9 timing seen so far
        chk(min_gap >= 2 * CLK_DIV, "R9 chip select gap", min_gap, 2 * CLK_DIV);
        chk(min_hi == CLK_DIV && max_hi == CLK_DIV, "R9 clock half period",
            {min_hi[15:0], max_hi[15:0]}, {16'(CLK_DIV), 16'(CLK_DIV)});

        // R5 absent memory
        do_reset(8, 1'b0, 1'b0);
        chk(dev_present == 1'b0, "R5 no memory detected", dev_present, 0);
        // R7 read with no memory
        begin
            int cs_seen = 0;
            fork
                begin
                    repeat (6) begin
                        @(posedge clk);
                        if (eep_cs) cs_seen++;
                    end
                end
                do_read(10'h123, d, cyc);
            join
            chk(d == 16'hFFFF && cyc == 0 && cs_seen == 0, "R7 absent read",
                {d, 8'(cyc), 8'(cs_seen)}, {16'hFFFF, 16'h0});
        end

        // R6 return line held low
        do_reset(8, 1'b1, 1'b1);
        chk(dev_present == 1'b0, "R6 line held low treated absent", dev_present, 0);
        m_stuck = 1'b0;

        summary();
        $finish;
    end
endmodule